// File: doc/BRIEF.md
# Synapse List Fetch and Dispatch

This block turns one spike event into the stream of synapse entries that the event fans out to. A request names a source (an axon or a neuron) and its index. The block looks up that source's 32-bit pointer word, splits it into a row count and a first row index, and then reads that many 256-bit synapse rows in turn. It unpacks each row into its eight 32-bit entries and sends each entry to one of two outputs, chosen by the entry's 3-bit type code.

Weight-carrying entries (regular and recurrent) leave on a weight-update port that carries the 13-bit target and the signed 16-bit weight. Report entries leave on a host-report port that carries only the neuron number. Both ports use valid/ready, and the walk waits while the selected port is not ready. The pointer table and the synapse-row table are modelled inside the block. Each has a plain write port used to load it, so no external memory controller is needed. Every row the walk reads is also shown as a byte address, which lets the layout be observed.

Top module: `syn_list_walker`

## Requirements
- R1: A pointer word is decoded with bits [31:23] as the row count and bits [22:0] as the first row index. The walk reads rows first, first+1, ... first+count-1, in that order.
- R2: The pointer of axon i sits at byte address 4*i, and the pointer of neuron i sits at byte address 0x4000 + 4*i. The pointer write port takes these byte addresses.
- R3: Each row read raises `row_fetch` for one cycle, and `row_fetch_addr` then shows 0x8000 + 32*row.
- R4: Within a row, the entries leave in order from slot 0 to slot 7. Slot k occupies bits [32k+31:32k]. At most one entry leaves per cycle, and when both outputs are always ready a walk of n rows raises `done` 2 + 9n cycles after the start cycle.
- R5: An entry is decoded with its type in bits [31:29], its target in bits [28:16] and its signed weight in bits [15:0].
- R6: Type 000 (regular) and type 101 (recurrent) go to the weight-update port with the target and the weight. `wu_recurrent` is 1 only for type 101.
- R7: Type 100 goes to the host-report port with its target as the neuron number. Its weight bits have no effect.
- R8: Entries of any other type are dropped and not presented on either port. Each one adds 1 to `err_count`, which saturates at its maximum and is cleared only by reset.
- R9: A pointer with a row count of zero reads no rows, and `done` rises two cycles after the start cycle.
- R10: While an output is valid and not ready, the walk stalls, and that output's valid and data stay unchanged.
- R11: `busy` is high from the cycle after a start until the last entry of the last row has left. In the next cycle `busy` is low and `done` is high for exactly one cycle.
- R12: A start request that arrives while `busy` is high is ignored.
- R13: After reset, `busy`, `done`, both valids, `row_fetch` and `err_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a walk for the named source |
| start_neuron | input | 1 | 1: source is a neuron, 0: source is an axon |
| start_id | input | ID_W | Source index |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| ptr_wr_en | input | 1 | Pointer table write strobe |
| ptr_wr_addr | input | 32 | Pointer byte address |
| ptr_wr_data | input | 32 | Pointer word |
| row_wr_en | input | 1 | Synapse row table write strobe |
| row_wr_idx | input | clog2(ROW_N) | Row index to write |
| row_wr_data | input | 256 | Row contents |
| row_fetch | output | 1 | A row is being read this cycle |
| row_fetch_addr | output | 32 | Byte address of that row |
| wu_valid | output | 1 | Weight-update entry valid |
| wu_ready | input | 1 | Weight-update consumer ready |
| wu_target | output | 13 | Target neuron of the entry |
| wu_weight | output | 16 | Signed weight |
| wu_recurrent | output | 1 | Entry is of the recurrent type |
| host_valid | output | 1 | Host-report entry valid |
| host_ready | input | 1 | Host-report consumer ready |
| host_neuron | output | 13 | Neuron to report |
| err_count | output | ERR_W | Saturating count of dropped entries |

## Verification
Every axon and neuron slot of a small table is walked, with row counts from zero to three, so that zero-length, single-row and multi-row pointers, and both pointer banks, are all exercised. The row contents mix all eight type codes. A misrouted, reordered or wrongly sliced entry therefore shows up as a mismatch against the sequence the bench derives. Each sweep is repeated with both consumers always ready, with ready alternating, and with ready driven pseudo-randomly. The first setting pins the exact cycle count. The other two separate a correct stall from a lost or duplicated entry. One walk gets a second start while it is busy, and the expected sequence and the single `done` pulse show that the second start was ignored.

// File: rtl/syn_walk_pkg.sv
package syn_walk_pkg;
  localparam logic [31:0] AXON_PTR_BASE   = 32'h0000_0000;
  localparam logic [31:0] NEURON_PTR_BASE = 32'h0000_4000;
  localparam logic [31:0] SYN_ROW_BASE    = 32'h0000_8000;
  localparam int          SLOTS   = 8;
  localparam int          ENTRY_W = 32;
  localparam int          ROW_W   = SLOTS * ENTRY_W;

  localparam logic [2:0] KIND_REGULAR = 3'b000;
  localparam logic [2:0] KIND_HOST    = 3'b100;
  localparam logic [2:0] KIND_RECUR   = 3'b101;

  typedef struct packed {
    logic [8:0]  rows;
    logic [22:0] first;
  } ptr_word_t;

  typedef struct packed {
    logic [2:0]  kind;
    logic [12:0] target;
    logic [15:0] weight;
  } syn_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PTR, ST_ROW, ST_DISP} walk_state_t;

  function automatic logic [31:0] ptr_byte_addr(input logic is_neuron, input logic [15:0] id);
    return (is_neuron ? NEURON_PTR_BASE : AXON_PTR_BASE) + {14'd0, id, 2'b00};
  endfunction

  function automatic logic [31:0] row_byte_addr(input logic [22:0] row);
    return SYN_ROW_BASE + {4'd0, row, 5'd0};
  endfunction
endpackage

// File: rtl/swd_ptr_store.sv
module swd_ptr_store
  import syn_walk_pkg::*;
#(
  parameter int AXON_N   = 16,
  parameter int NEURON_N = 16
) (
  input  logic        clk,
  input  logic        wr_en,
  input  logic [31:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [31:0] rd_addr,
  output logic [31:0] rd_data
);
  localparam int AW = (AXON_N > 1) ? $clog2(AXON_N) : 1;
  localparam int NW = (NEURON_N > 1) ? $clog2(NEURON_N) : 1;

  logic [31:0] axon_mem   [AXON_N];
  logic [31:0] neuron_mem [NEURON_N];

  logic [31:0] w_off_a, w_off_n, r_off_a, r_off_n;
  logic        w_in_a, w_in_n, r_in_a, r_in_n;

  assign w_off_a = wr_addr - AXON_PTR_BASE;
  assign w_off_n = wr_addr - NEURON_PTR_BASE;
  assign r_off_a = rd_addr - AXON_PTR_BASE;
  assign r_off_n = rd_addr - NEURON_PTR_BASE;

  assign w_in_a = (wr_addr < NEURON_PTR_BASE) && (w_off_a[1:0] == 2'b00)
                  && (w_off_a[31:2] < 30'(AXON_N));
  assign w_in_n = (wr_addr >= NEURON_PTR_BASE) && (w_off_n[1:0] == 2'b00)
                  && (w_off_n[31:2] < 30'(NEURON_N));
  assign r_in_a = (rd_addr < NEURON_PTR_BASE) && (r_off_a[1:0] == 2'b00)
                  && (r_off_a[31:2] < 30'(AXON_N));
  assign r_in_n = (rd_addr >= NEURON_PTR_BASE) && (r_off_n[1:0] == 2'b00)
                  && (r_off_n[31:2] < 30'(NEURON_N));

  always_ff @(posedge clk) begin
    if (wr_en && w_in_a) axon_mem[w_off_a[AW+1:2]] <= wr_data;
    if (wr_en && w_in_n) neuron_mem[w_off_n[NW+1:2]] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (r_in_a) rd_data = axon_mem[r_off_a[AW+1:2]];
    else if (r_in_n) rd_data = neuron_mem[r_off_n[NW+1:2]];
  end
endmodule

// File: rtl/swd_row_store.sv
module swd_row_store
  import syn_walk_pkg::*;
#(
  parameter int ROW_N = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(ROW_N)-1:0] wr_idx,
  input  logic [ROW_W-1:0]         wr_data,
  input  logic [$clog2(ROW_N)-1:0] rd_idx,
  output logic [ROW_W-1:0]         rd_data
);
  logic [ROW_W-1:0] mem [ROW_N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/swd_entry_router.sv
module swd_entry_router
  import syn_walk_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output logic               to_weight,
  output logic               to_host,
  output logic               is_bad,
  output logic               recurrent,
  output logic [12:0]        target,
  output logic [15:0]        weight
);
  syn_word_t w;
  assign w      = syn_word_t'(entry);
  assign target = w.target;
  assign weight = w.weight;

  always_comb begin
    to_weight = 1'b0;
    to_host   = 1'b0;
    recurrent = 1'b0;
    unique case (w.kind)
      KIND_REGULAR: to_weight = 1'b1;
      KIND_RECUR: begin
        to_weight = 1'b1;
        recurrent = 1'b1;
      end
      KIND_HOST:    to_host = 1'b1;
      default: ;
    endcase
  end

  assign is_bad = !to_weight && !to_host;
endmodule

// File: rtl/syn_list_walker.sv
module syn_list_walker
  import syn_walk_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int AXON_N   = 16,
  parameter int NEURON_N = 16,
  parameter int ROW_N    = 32,
  parameter int ERR_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     start_neuron,
  input  logic [ID_W-1:0]          start_id,
  output logic                     busy,
  output logic                     done,
  input  logic                     ptr_wr_en,
  input  logic [31:0]              ptr_wr_addr,
  input  logic [31:0]              ptr_wr_data,
  input  logic                     row_wr_en,
  input  logic [$clog2(ROW_N)-1:0] row_wr_idx,
  input  logic [255:0]             row_wr_data,
  output logic                     row_fetch,
  output logic [31:0]              row_fetch_addr,
  output logic                     wu_valid,
  input  logic                     wu_ready,
  output logic [12:0]              wu_target,
  output logic [15:0]              wu_weight,
  output logic                     wu_recurrent,
  output logic                     host_valid,
  input  logic                     host_ready,
  output logic [12:0]              host_neuron,
  output logic [ERR_W-1:0]         err_count
);
  localparam int ROW_AW = $clog2(ROW_N);
  localparam int SLOT_W = $clog2(SLOTS);

  walk_state_t        state;
  logic               kind_q;
  logic [ID_W-1:0]    id_q;
  logic [8:0]         rows_left;
  logic [22:0]        cur_row;
  logic [ROW_W-1:0]   row_q;
  logic [SLOT_W-1:0]  slot;
  logic               done_q;
  logic [ERR_W-1:0]   err_q;

  logic [31:0]        ptr_rd_data;
  ptr_word_t          ptr_w;
  logic [ROW_W-1:0]   row_rd_data;
  logic [ENTRY_W-1:0] cur_entry;
  logic               r_weight, r_host, r_bad, r_recur;
  logic [12:0]        r_target;
  logic [15:0]        r_weight_val;

  // named events
  logic accept_start, slot_fire, last_slot, last_row, walk_finish, empty_ptr;

  swd_ptr_store #(.AXON_N(AXON_N), .NEURON_N(NEURON_N)) u_ptr (
    .clk     (clk),
    .wr_en   (ptr_wr_en),
    .wr_addr (ptr_wr_addr),
    .wr_data (ptr_wr_data),
    .rd_addr (ptr_byte_addr(kind_q, 16'(id_q))),
    .rd_data (ptr_rd_data)
  );

  swd_row_store #(.ROW_N(ROW_N)) u_rows (
    .clk     (clk),
    .wr_en   (row_wr_en),
    .wr_idx  (row_wr_idx),
    .wr_data (row_wr_data),
    .rd_idx  (cur_row[ROW_AW-1:0]),
    .rd_data (row_rd_data)
  );

  assign ptr_w     = ptr_word_t'(ptr_rd_data);
  assign cur_entry = row_q[{slot, 5'd0} +: ENTRY_W];

  swd_entry_router u_route (
    .entry     (cur_entry),
    .to_weight (r_weight),
    .to_host   (r_host),
    .is_bad    (r_bad),
    .recurrent (r_recur),
    .target    (r_target),
    .weight    (r_weight_val)
  );

  assign accept_start = start && (state == ST_IDLE);
  assign empty_ptr    = (state == ST_PTR) && (ptr_w.rows == 9'd0);
  assign slot_fire    = (state == ST_DISP) &&
                        (r_bad || (r_weight && wu_ready) || (r_host && host_ready));
  assign last_slot    = (slot == SLOT_W'(SLOTS - 1));
  assign last_row     = (rows_left == 9'd1);
  assign walk_finish  = slot_fire && last_slot && last_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= 1'b0;
      id_q      <= '0;
      rows_left <= '0;
      cur_row   <= '0;
      row_q     <= '0;
      slot      <= '0;
      done_q    <= 1'b0;
      err_q     <= '0;
    end else begin
      done_q <= empty_ptr || walk_finish;
      if (slot_fire && r_bad && (err_q != '1)) err_q <= err_q + 1'b1;
      unique case (state)
        ST_IDLE: if (accept_start) begin
          kind_q <= start_neuron;
          id_q   <= start_id;
          state  <= ST_PTR;
        end
        ST_PTR: begin
          rows_left <= ptr_w.rows;
          cur_row   <= ptr_w.first;
          state     <= empty_ptr ? ST_IDLE : ST_ROW;
        end
        ST_ROW: begin
          row_q <= row_rd_data;
          slot  <= '0;
          state <= ST_DISP;
        end
        ST_DISP: if (slot_fire) begin
          if (!last_slot) begin
            slot <= slot + 1'b1;
          end else if (last_row) begin
            state <= ST_IDLE;
          end else begin
            rows_left <= rows_left - 9'd1;
            cur_row   <= cur_row + 23'd1;
            state     <= ST_ROW;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (state != ST_IDLE);
  assign done           = done_q;
  assign row_fetch      = (state == ST_ROW);
  assign row_fetch_addr = row_byte_addr(cur_row);
  assign wu_valid       = (state == ST_DISP) && r_weight;
  assign wu_target      = r_target;
  assign wu_weight      = r_weight_val;
  assign wu_recurrent   = r_recur;
  assign host_valid     = (state == ST_DISP) && r_host;
  assign host_neuron    = r_target;
  assign err_count      = err_q;
endmodule

// File: rtl/syn_list_walker_chk.sv
module syn_list_walker_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             row_fetch,
  input logic [31:0]      row_fetch_addr,
  input logic             wu_valid,
  input logic             wu_ready,
  input logic [12:0]      wu_target,
  input logic [15:0]      wu_weight,
  input logic             wu_recurrent,
  input logic             host_valid,
  input logic             host_ready,
  input logic [12:0]      host_neuron,
  input logic [ERR_W-1:0] err_count
);
  assert_wu_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wu_valid && !wu_ready) |=> (wu_valid && $stable(wu_target) && $stable(wu_weight)
                                 && $stable(wu_recurrent)));

  assert_host_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_neuron)));

  assert_one_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wu_valid && host_valid));

  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_valid_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wu_valid || host_valid || row_fetch) |-> busy);

  assert_err_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

  assert_fetch_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_fetch |-> ((row_fetch_addr[4:0] == 5'd0) && (row_fetch_addr >= 32'h8000)));
endmodule

bind syn_list_walker syn_list_walker_chk #(.ERR_W(ERR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .done           (done),
  .row_fetch      (row_fetch),
  .row_fetch_addr (row_fetch_addr),
  .wu_valid       (wu_valid),
  .wu_ready       (wu_ready),
  .wu_target      (wu_target),
  .wu_weight      (wu_weight),
  .wu_recurrent   (wu_recurrent),
  .host_valid     (host_valid),
  .host_ready     (host_ready),
  .host_neuron    (host_neuron),
  .err_count      (err_count)
);

// File: tb/syn_list_walker_bench.sv
module syn_list_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int NROW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_neuron = 1'b0;
  logic [15:0] start_id = '0;
  logic busy, done;
  logic ptr_wr_en = 1'b0;
  logic [31:0] ptr_wr_addr = '0, ptr_wr_data = '0;
  logic row_wr_en = 1'b0;
  logic [4:0] row_wr_idx = '0;
  logic [255:0] row_wr_data = '0;
  logic row_fetch;
  logic [31:0] row_fetch_addr;
  logic wu_valid, wu_ready, wu_recurrent;
  logic [12:0] wu_target, host_neuron;
  logic [15:0] wu_weight;
  logic host_valid, host_ready;
  logic [7:0] err_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  syn_list_walker u_syn_list_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_neuron(start_neuron),
    .start_id(start_id), .busy(busy), .done(done),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_addr(ptr_wr_addr), .ptr_wr_data(ptr_wr_data),
    .row_wr_en(row_wr_en), .row_wr_idx(row_wr_idx), .row_wr_data(row_wr_data),
    .row_fetch(row_fetch), .row_fetch_addr(row_fetch_addr),
    .wu_valid(wu_valid), .wu_ready(wu_ready), .wu_target(wu_target),
    .wu_weight(wu_weight), .wu_recurrent(wu_recurrent),
    .host_valid(host_valid), .host_ready(host_ready), .host_neuron(host_neuron),
    .err_count(err_count)
  );

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench copy of the tables
  logic [31:0]  b_ax [NSRC];
  logic [31:0]  b_nr [NSRC];
  logic [255:0] b_row [NROW];
  logic [31:0]  lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // ready patterns
  int mode = 0;
  logic [31:0] rlfsr = 32'h0BAD_F00D;
  logic tgl = 1'b0;
  assign wu_ready   = (mode == 0) ? 1'b1 : (mode == 1) ? tgl  : rlfsr[3];
  assign host_ready = (mode == 0) ? 1'b1 : (mode == 1) ? !tgl : rlfsr[7];
  always @(posedge clk) begin
    #1;
    tgl   <= ~tgl;
    rlfsr <= step(rlfsr);
  end

  // collector
  int n_wu, n_host, n_fetch, n_done, cyc, done_cyc;
  logic [12:0] g_wt [64];
  logic [15:0] g_ww [64];
  logic        g_wr [64];
  logic [12:0] g_hn [64];
  logic [31:0] g_fa [64];
  always @(negedge clk) begin
    if (start && !busy) begin
      n_wu = 0; n_host = 0; n_fetch = 0; n_done = 0; cyc = 0; done_cyc = -1;
    end else begin
      cyc++;
      if (wu_valid && wu_ready && n_wu < 64) begin
        g_wt[n_wu] = wu_target; g_ww[n_wu] = wu_weight; g_wr[n_wu] = wu_recurrent; n_wu++;
      end
      if (host_valid && host_ready && n_host < 64) begin
        g_hn[n_host] = host_neuron; n_host++;
      end
      if (row_fetch && n_fetch < 64) begin g_fa[n_fetch] = row_fetch_addr; n_fetch++; end
      if (done) begin n_done++; if (done_cyc < 0) done_cyc = cyc; end
    end
  end

  int bad_total = 0;

  task automatic run_walk(input logic nk, input int id, input bit restart);
    logic [31:0] p;
    int nrows, first, ew, eh, eb, got_done;
    logic [31:0] e;
    p = nk ? b_nr[id] : b_ax[id];
    nrows = int'(p[31:23]); first = int'(p[22:0]);
    @(posedge clk); #1;
    start = 1'b1; start_neuron = nk; start_id = 16'(id);
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    if (restart) begin  // second request while busy, different source
      start = 1'b1; start_neuron = !nk; start_id = 16'((id + 5) % NSRC);
      @(posedge clk); #1;
      start = 1'b0;
    end
    got_done = 0;
    for (int t = 0; t < 600 && !got_done; t++) begin
      @(posedge clk);
      if (n_done > 0) got_done = 1;
    end
    if (!got_done) begin
      check(0, "R11", "watchdog done", 0, 1);
      return;
    end
    repeat (4) @(posedge clk);
    #1;
    check(n_done == 1, "R11", "done pulses", n_done, 1);
    check(!busy, "R12", "busy after done", busy, 0);
    check(n_fetch == nrows, "R1", "row reads", n_fetch, nrows);
    ew = 0; eh = 0; eb = 0;
    for (int r = 0; r < nrows; r++) begin
      if (r < n_fetch)
        check(g_fa[r] == 32'h8000 + 32'(first + r) * 32, "R3", "row address",
              g_fa[r], 32'h8000 + 32'(first + r) * 32);
      for (int k = 0; k < 8; k++) begin
        e = b_row[first + r][32*k +: 32];
        if (e[31:29] == 3'b000 || e[31:29] == 3'b101) begin
          if (ew < n_wu) begin
            check(g_wt[ew] == e[28:16], "R5", "wu target", g_wt[ew], e[28:16]);
            check(g_ww[ew] == e[15:0], "R5", "wu weight", g_ww[ew], e[15:0]);
            check(g_wr[ew] == (e[31:29] == 3'b101), "R6", "recurrent flag",
                  g_wr[ew], e[31:29] == 3'b101);
          end
          ew++;
        end else if (e[31:29] == 3'b100) begin
          if (eh < n_host) check(g_hn[eh] == e[28:16], "R7", "host neuron", g_hn[eh], e[28:16]);
          eh++;
        end else eb++;
      end
    end
    check(n_wu == ew, "R4", "weight entries", n_wu, ew);
    check(n_host == eh, "R7", "host entries", n_host, eh);
    bad_total += eb;
    check(err_count == 8'((bad_total > 255) ? 255 : bad_total), "R8", "err count",
          err_count, (bad_total > 255) ? 255 : bad_total);
    if (nrows == 0) check(done_cyc == 2, "R9", "empty done latency", done_cyc, 2);
    else if (mode == 0) check(done_cyc == 2 + 9 * nrows, "R4", "walk cycles",
                              done_cyc, 2 + 9 * nrows);
  endtask

  initial begin
    int kinds [8];
    kinds = '{3'b000, 3'b100, 3'b101, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    for (int r = 0; r < NROW; r++)
      for (int k = 0; k < 8; k++) begin
        lfsr = step(lfsr);
        b_row[r][32*k +: 32] = {3'(kinds[lfsr[2:0]]), lfsr[28:16], lfsr[31:29], lfsr[12:0]};
      end
    for (int i = 0; i < NSRC; i++) begin
      b_ax[i] = {9'(i % 4), 23'((i * 7) % 29)};
      b_nr[i] = {9'((i + 1) % 4), 23'((i * 7 + 3) % 29)};
    end
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !wu_valid && !host_valid && !row_fetch, "R13", "reset outputs",
          {busy, done, wu_valid, host_valid, row_fetch}, 0);
    check(err_count == 0, "R13", "reset err", err_count, 0);
    rst_n = 1'b1;
    for (int r = 0; r < NROW; r++) begin
      @(posedge clk); #1;
      row_wr_en = 1'b1; row_wr_idx = 5'(r); row_wr_data = b_row[r];
    end
    for (int i = 0; i < 2 * NSRC; i++) begin
      @(posedge clk); #1;
      row_wr_en = 1'b0;
      ptr_wr_en = 1'b1;  // R2: byte addresses of the two pointer banks
      ptr_wr_addr = (i < NSRC) ? 32'(4 * i) : 32'h4000 + 32'(4 * (i - NSRC));
      ptr_wr_data = (i < NSRC) ? b_ax[i] : b_nr[i - NSRC];
    end
    @(posedge clk); #1;
    ptr_wr_en = 1'b0;
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int nk = 0; nk < 2; nk++)
        for (int i = 0; i < NSRC; i++)
          run_walk(nk[0], i, (m == 2 && i == 5));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule